// File: doc/BRIEF.md
# Two-Wire Register Target with Pointer Auto-Increment

This block is a target on a two-wire, byte-oriented serial bus (I2C-style). It gives a bus master read and write access to a small file of 8-bit registers. Both bus lines are open-drain. Each line is seen through an input and driven through a pull-low enable. The block samples both lines on a fast system clock. It synchronises them, filters out short glitches, and derives START, STOP and SCL edge events from the filtered lines.

A write transaction carries three kinds of byte in turn: the address byte, a sub-address byte and then any number of data bytes. Bit 7 of the sub-address turns on pointer auto-increment, and bits 6:0 load the register pointer. A read transaction returns bytes from the current pointer. The usual way to read a chosen register is to write the sub-address and then issue a repeated START followed by a read address. When the register side is not ready, the `busy_i` input makes the target hold SCL low at a byte boundary. This is clock stretching.

The controller has nine states:
- `ST_IDLE` waits for a START.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK`, `ST_SUB_ACK` and `ST_WR_ACK` drive the acknowledge slot.
- `ST_SUB` takes the sub-address.
- `ST_WR` takes data bytes.
- `ST_RD` shifts a byte out.
- `ST_RD_ACK` samples the master's acknowledge.

All transitions below happen on a filtered SCL falling edge, except the two that apply in every state: START moves to `ST_ADDR` and STOP moves to `ST_IDLE`.
- From `ST_ADDR`, a full byte moves to `ST_ADDR_ACK` on an address match, and to `ST_IDLE` on a mismatch.
- `ST_ADDR_ACK` moves to `ST_RD` for a read and to `ST_SUB` for a write.
- A full byte in `ST_SUB` moves to `ST_SUB_ACK`, which then moves to `ST_WR`.
- A full byte in `ST_WR` moves to `ST_WR_ACK`, which then moves back to `ST_WR`.
- The eighth bit in `ST_RD` moves to `ST_RD_ACK`.
- `ST_RD_ACK` moves to `ST_RD` on a master ACK and to `ST_IDLE` on a NACK.

Top module: `tw_reg_target`

## Requirements
- R1: After reset the target leaves both lines released (`scl_oe`=0, `sda_oe`=0). The pointer is 0, auto-increment is off and every register reads 0x00.
- R2: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. Both are honoured in any state. A START, even in the middle of a byte, restarts address reception. A write byte cut short by a START or STOP is not stored.
- R3: The address byte is the 7-bit target address, MSB first, followed by a direction bit (1 = read). On a match the target pulls SDA low for the acknowledge slot. On a mismatch it keeps SDA released for that slot and for every later byte until the next START.
- R4: In a write, the first byte after the address is the sub-address. Each later byte is stored in the register the pointer selects, and every byte is acknowledged.
- R5: When sub-address bit 7 is 1, the 7-bit pointer advances by one after every data byte written or read. It wraps from 127 to 0.
- R6: When sub-address bit 7 is 0, the pointer does not move, so successive data bytes all access one register. Other registers are left unchanged.
- R7: In a read, the target shifts out the register at the pointer, MSB first. A master ACK (SDA low) after a byte requests the next byte. A master NACK makes the target release SDA and stop sending.
- R8: A repeated START or a STOP keeps the pointer and the auto-increment mode. This means a read that follows a sub-address write, or a later read with no sub-address, starts at the kept pointer.
- R9: When the pointer is at or above the number of registers, written bytes are still acknowledged but discarded, and reads return 0x00.
- R10: The target changes its SDA drive only while SCL is low, and it holds that level through the following SCL high phase.
- R11: If `busy_i` is high at the SCL falling edge that opens the acknowledge slot of a byte the target acknowledges, the target holds SCL low until `busy_i` drops. It then releases SCL within a few system clocks.
- R12: A pulse on SDA or SCL that lasts fewer than `FILT_LEN` system clocks after synchronisation has no effect on the bus state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| scl_oe | output | 1 | Pull SCL low (clock stretch) when 1 |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy_i | input | 1 | Register side not ready; requests clock stretching |

## Verification
The bench builds the target with address 0x3A, eight registers and a filter length of 3. With only eight registers, an out-of-range pointer is easy to reach, and so is the wrap from 127 to 0, which runs through a discarded write. With a filter length of 3, a single-cycle SDA pulse inserted while SCL is high is a glitch the filter has to reject. Without the filter, that pulse would look like a false START and STOP in the middle of a write. The bench also covers a repeated START in the middle of a byte, an aborted write, and a stretch held for a known number of cycles.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;

    localparam int PTR_W  = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tw_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } tw_evt_t;

endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    meta_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 2'b11;
            cnt_q  <= '0;
            filt_o <= 1'b1;
        end else begin
            meta_q <= {meta_q[0], line_i};
            if (meta_q[1] == filt_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                filt_o <= meta_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R12: the filtered level only ever moves to the synchronised level
    p_filter_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> (filt_o == $past(meta_q[1])));

endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events
    import tw_reg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output tw_evt_t evt
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    always_comb begin
        evt.start = scl_d & scl_f & sda_d & ~sda_f;
        evt.stop  = scl_d & scl_f & ~sda_d & sda_f;
        evt.rise  = ~scl_d & scl_f;
        evt.fall  = scl_d & ~scl_f;
    end

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
    import tw_reg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && ptr == PTR_W'(g)) begin
                mem[g] <= wr_data;
            end
        end

        // R9: a register changes only when the write targets its own index
        p_reg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && ptr == PTR_W'(g)) |=> $stable(mem[g]));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ptr == PTR_W'(i)) rd_data = mem[i];
        end
    end

endmodule

// File: rtl/tw_reg_target.sv
module tw_reg_target
    import tw_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3A,
    parameter int         NUM_REGS = 16,
    parameter int         FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic scl_oe,
    input  logic sda_i,
    output logic sda_oe,
    input  logic busy_i
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic              scl_f, sda_f;
    tw_evt_t           evt;

    assign raw_lines = {sda_i, scl_i};

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        tw_line_filter #(.FILT_LEN(FILT_LEN)) i_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[l]),
            .filt_o (filt_lines[l])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    tw_bus_events i_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .evt   (evt)
    );

    tw_state_e         state, nxt;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg, tx_q, rd_data;
    logic [PTR_W-1:0]  ptr_q;
    logic              inc_q, rw_q, mack_q, hold_q;
    logic              byte_done, addr_hit, wr_en;

    assign byte_done = (bit_cnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign wr_en     = (state == ST_WR) && evt.fall && byte_done;
    assign scl_oe    = hold_q;

    tw_regfile #(.NUM_REGS(NUM_REGS)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .ptr     (ptr_q),
        .wr_data (shreg),
        .rd_data (rd_data)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (evt.start) begin
            nxt = ST_ADDR;
        end else if (evt.stop) begin
            nxt = ST_IDLE;
        end else if (evt.fall) begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: nxt = rw_q ? ST_RD : ST_SUB;
                ST_SUB:      if (byte_done) nxt = ST_SUB_ACK;
                ST_SUB_ACK:  nxt = ST_WR;
                ST_WR:       if (byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   nxt = ST_WR;
                ST_RD:       if (bit_cnt == 4'd7) nxt = ST_RD_ACK;
                ST_RD_ACK:   nxt = mack_q ? ST_RD : ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and line drivers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            inc_q   <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            hold_q  <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            if (hold_q && !busy_i) hold_q <= 1'b0;
            if (evt.start) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (evt.stop) begin
                sda_oe  <= 1'b0;
            end else begin
                if (evt.rise) begin
                    unique case (state)
                        ST_ADDR, ST_SUB, ST_WR: begin
                            if (!byte_done) begin
                                shreg   <= {shreg[6:0], sda_f};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                        ST_RD_ACK: mack_q <= ~sda_f;
                        default: ;
                    endcase
                end
                if (evt.fall) begin
                    unique case (state)
                        ST_ADDR: begin
                            if (byte_done && addr_hit) begin
                                sda_oe <= 1'b1;
                                rw_q   <= shreg[0];
                                if (busy_i) hold_q <= 1'b1;
                            end
                        end
                        ST_ADDR_ACK: begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                tx_q   <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                        ST_SUB: begin
                            if (byte_done) begin
                                ptr_q  <= shreg[6:0];
                                inc_q  <= shreg[7];
                                sda_oe <= 1'b1;
                                if (busy_i) hold_q <= 1'b1;
                            end
                        end
                        ST_WR: begin
                            if (byte_done) begin
                                sda_oe <= 1'b1;
                                if (inc_q) ptr_q <= ptr_q + 7'd1;
                                if (busy_i) hold_q <= 1'b1;
                            end
                        end
                        ST_SUB_ACK, ST_WR_ACK: begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                        end
                        ST_RD: begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                if (inc_q) ptr_q <= ptr_q + 7'd1;
                            end else begin
                                bit_cnt <= bit_cnt + 4'd1;
                                tx_q    <= {tx_q[6:0], 1'b0};
                                sda_oe  <= ~tx_q[6];
                            end
                        end
                        ST_RD_ACK: begin
                            bit_cnt <= '0;
                            if (mack_q) begin
                                tx_q   <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R10: SDA drive changes only while the filtered SCL is low
    p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R11: a stretch begins only when busy was seen, and ends once busy drops
    p_stretch_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(busy_i));
    p_stretch_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !busy_i) |=> !scl_oe);

    // R2: a START always leads back to address reception
    p_start_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (state == ST_ADDR));

    // R3: a foreign address leaves SDA released and parks the FSM
    p_foreign_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && evt.fall && byte_done && !addr_hit)
        |=> (!sda_oe && state == ST_IDLE));

    // R5: auto-increment steps the pointer by one per written byte
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inc_q) |=> (ptr_q == 7'($past(ptr_q) + 7'd1)));

    // R6: without auto-increment the pointer only moves on a sub-address
    p_ptr_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_q && state != ST_SUB) |=> $stable(ptr_q));

endmodule

// File: tb/test_tw_reg_target.sv
`timescale 1ns/1ps
module test_tw_reg_target;

    localparam logic [6:0] DEV  = 7'h3A;
    localparam int         HALF = 25;
    localparam int         QTR  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic busy = 1'b0;
    logic scl_oe, sda_oe;
    logic scl_line, sda_line;
    logic glitch_arm = 1'b0;
    logic done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int r10_viol = 0;

    logic [7:0] exp_q[$];
    logic [7:0] obs_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    assign scl_line = ~(m_scl_low | scl_oe);
    assign sda_line = ~(m_sda_low | sda_oe);

    tw_reg_target #(.DEV_ADDR(DEV), .NUM_REGS(8), .FILT_LEN(3)) i_tw_reg_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_line),
        .scl_oe (scl_oe),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .busy_i (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_release();
        int t = 0;
        m_scl_low = 1'b0;
        while (!scl_line && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) chk(1'b0, "R11 SCL never released", 8'd0, 8'd1);
    endtask

    task automatic put_bit(input bit b);
        wait_clk(QTR);
        m_sda_low = ~b;
        wait_clk(HALF - QTR);
        scl_release();
        if (glitch_arm && b) begin
            wait_clk(6);
            m_sda_low = 1'b1;
            wait_clk(1);
            m_sda_low = 1'b0;
            glitch_arm = 1'b0;
            wait_clk(HALF - 7);
        end else begin
            wait_clk(HALF);
        end
        m_scl_low = 1'b1;
    endtask

    task automatic get_bit(output bit b);
        wait_clk(QTR);
        m_sda_low = 1'b0;
        wait_clk(HALF - QTR);
        scl_release();
        wait_clk(HALF / 2);
        b = sda_line;
        wait_clk(HALF - HALF / 2);
        m_scl_low = 1'b1;
    endtask

    task automatic start_c();
        if (m_scl_low) begin
            wait_clk(QTR);
            m_sda_low = 1'b0;
            wait_clk(HALF - QTR);
            scl_release();
            wait_clk(HALF / 2);
        end
        m_sda_low = 1'b1;
        wait_clk(HALF / 2);
        m_scl_low = 1'b1;
    endtask

    task automatic stop_c();
        wait_clk(QTR);
        m_sda_low = 1'b1;
        wait_clk(HALF - QTR);
        scl_release();
        wait_clk(HALF / 2);
        m_sda_low = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic put_byte(input logic [7:0] d, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic get_byte(output logic [7:0] d, input bit mack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~mack);
    endtask

    // driver: write n bytes (MSB-first in bytes) after sub-address sub
    task automatic wr_seq(input logic [7:0] sub, input int n, input logic [31:0] bytes, input string req);
        bit ack;
        start_c();
        put_byte({DEV, 1'b0}, ack);
        chk(ack, {req, " address ack"}, {7'd0, ack}, 8'd1);
        put_byte(sub, ack);
        chk(ack, {req, " sub-address ack"}, {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            put_byte(bytes[31 - 8*k -: 8], ack);
            chk(ack, {req, " data ack"}, {7'd0, ack}, 8'd1);
        end
        stop_c();
    endtask

    // driver: optional sub-address write, then read n bytes; expected go to scoreboard
    task automatic rd_seq(input bit use_sub, input logic [7:0] sub, input int n,
                          input logic [31:0] exp, input string req);
        bit ack;
        logic [7:0] d;
        start_c();
        if (use_sub) begin
            put_byte({DEV, 1'b0}, ack);
            chk(ack, {req, " address ack"}, {7'd0, ack}, 8'd1);
            put_byte(sub, ack);
            chk(ack, {req, " sub-address ack"}, {7'd0, ack}, 8'd1);
            start_c();
        end
        put_byte({DEV, 1'b1}, ack);
        chk(ack, {req, " read address ack"}, {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(exp[31 - 8*k -: 8]);
            tag_q.push_back(req);
            get_byte(d, k < n - 1);
            obs_q.push_back(d);
        end
        wait_clk(QTR);
        chk(!sda_oe, "R7 SDA released after NACK", {7'd0, sda_oe}, 8'd0);
        stop_c();
    endtask

    // monitor: compares read bytes against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                logic [7:0] o, e;
                string t;
                o = obs_q.pop_front();
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                t = (tag_q.size() > 0) ? tag_q.pop_front() : "scoreboard";
                chk(o === e, {t, " read data"}, o, e);
            end
        end
    end

    // R10: SDA drive must not move while the SCL line is high
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (sda_oe !== prev) && scl_line) r10_viol++;
            prev = sda_oe;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 8'd0, 8'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack, bad;
        logic [7:0] d;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(10);

        // R1: reset state
        chk(!sda_oe, "R1 sda_oe after reset", {7'd0, sda_oe}, 8'd0);
        chk(!scl_oe, "R1 scl_oe after reset", {7'd0, scl_oe}, 8'd0);
        rd_seq(1'b0, 8'h00, 1, 32'h00_000000, "R1 reset register via pointer 0");

        // R4/R5: auto-increment burst write, then R7/R8 restart read
        wr_seq(8'h81, 4, 32'h11223344, "R4");
        rd_seq(1'b1, 8'h81, 3, 32'h112233_00, "R5 R8 burst read");
        rd_seq(1'b0, 8'h00, 1, 32'h44_000000, "R8 pointer kept over STOP");

        // R6: fixed pointer
        wr_seq(8'h05, 2, 32'h6C55_0000, "R6");
        rd_seq(1'b1, 8'h05, 2, 32'h5555_0000, "R6 fixed-pointer read");
        rd_seq(1'b1, 8'h86, 1, 32'h00_000000, "R6 neighbour untouched");

        // R3: foreign address is ignored
        start_c();
        put_byte({7'h3B, 1'b0}, ack);
        chk(!ack, "R3 foreign address not acked", {7'd0, ack}, 8'd0);
        put_byte(8'h01, ack);
        chk(!ack, "R3 later byte not acked", {7'd0, ack}, 8'd0);
        put_byte(8'h99, ack);
        chk(!ack, "R3 data byte not acked", {7'd0, ack}, 8'd0);
        stop_c();
        rd_seq(1'b1, 8'h01, 1, 32'h11_000000, "R3 register unchanged");

        // R9 and R5 wrap: 127 discarded, wraps to 0
        wr_seq(8'hFF, 2, 32'hABCD_0000, "R9");
        rd_seq(1'b1, 8'h80, 1, 32'hCD_000000, "R5 wrap to register 0");
        rd_seq(1'b1, 8'h7F, 1, 32'h00_000000, "R9 out-of-range reads zero");

        // R11: clock stretching on the data byte acknowledge
        start_c();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h02, ack);
        busy = 1'b1;
        bad = 1'b0;
        fork
            put_byte(8'h5A, ack);
            begin
                int t = 0;
                while (!scl_oe && t < 3000) begin
                    wait_clk(1);
                    t++;
                end
                chk(scl_oe, "R11 stretch begins", {7'd0, scl_oe}, 8'd1);
                repeat (40) begin
                    wait_clk(1);
                    if (!scl_oe || scl_line) bad = 1'b1;
                end
                chk(!bad, "R11 SCL held while busy", {7'd0, bad}, 8'd0);
                busy = 1'b0;
                wait_clk(3);
                chk(!scl_oe, "R11 SCL released after busy", {7'd0, scl_oe}, 8'd0);
            end
        join
        chk(ack, "R11 stretched byte acked", {7'd0, ack}, 8'd1);
        stop_c();
        rd_seq(1'b1, 8'h02, 1, 32'h5A_000000, "R11 stretched write stored");

        // R12: single-cycle SDA glitch while SCL high
        start_c();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h03, ack);
        glitch_arm = 1'b1;
        put_byte(8'hC3, ack);
        chk(ack, "R12 byte with glitch acked", {7'd0, ack}, 8'd1);
        stop_c();
        rd_seq(1'b1, 8'h03, 1, 32'hC3_000000, "R12 glitch rejected");

        // R2: STOP in the middle of a byte discards it
        start_c();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h06, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        stop_c();
        rd_seq(1'b1, 8'h06, 1, 32'h00_000000, "R2 aborted write not stored");

        // R2: repeated START in the middle of a byte restarts address reception
        start_c();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h07, ack);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        start_c();
        put_byte({DEV, 1'b1}, ack);
        chk(ack, "R2 address after mid-byte START acked", {7'd0, ack}, 8'd1);
        exp_q.push_back(8'h00);
        tag_q.push_back("R2 read after mid-byte START");
        get_byte(d, 1'b0);
        obs_q.push_back(d);
        stop_c();

        wait_clk(20);
        chk(r10_viol == 0, "R10 SDA moved while SCL high", 8'(r10_viol), 8'd0);
        chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule